// File: doc/BRIEF.md
# Gray-Coded Receiver Converter Sampler

This block sits on the host side of a low-frequency radio time-code receiver whose analog front end ends in a small converter with a 4-bit Gray-coded output. The block generates the converter clock by dividing the system clock. Each edge of that clock starts a conversion, and the level of the clock selects what is converted. During the high phase the result is the received field strength. During the low phase it is the demodulated time-code amplitude. The block waits a programmable number of system cycles after each edge, samples the four data lines and converts the Gray word to binary. It then presents the result on one of two separate streams, each with its own one-cycle strobe.

The block also drives the receiver's power-down line. While the enable input is low, the receiver is held powered down, the converter clock is parked low and no samples are produced. In that state the data lines of the front end all read high, and that pattern never reaches the output streams. After each rise of the enable input, the block suppresses samples for a programmable start-up interval while the analog chain settles.

Top module: `gray_adc_sampler`

## Requirements
- R1: While reset is asserted and right after it, `rx_pwr_dn` is 1, `conv_clk` is 0, both strobes are 0 and both value outputs are 0.
- R2: `rx_pwr_dn` is the inverse of `enable` as sampled at the previous rising edge of `clk`: 1 means the receiver is powered down.
- R3: While enabled, `conv_clk` starts low and inverts after every `HALF_TICKS` enabled cycles. Any cycle with `enable` low returns it to low and restarts its timing.
- R4: After `enable` rises, no strobe is produced during the first `SETUP_TICKS` enabled cycles. The start-up interval restarts every time `enable` falls and rises again.
- R5: A sample is taken at the `CAPTURE_TICKS`-th enabled cycle after a converter clock edge, where 1 ≤ `CAPTURE_TICKS` < `HALF_TICKS`. Its strobe is high in the cycle that follows that edge of `clk`, and it carries the data lines as they stood at that edge.
- R6: Samples taken while `conv_clk` is high raise `fs_valid`, and samples taken while it is low raise `tc_valid`. Each strobe lasts one cycle and fires at most once per phase. The two strobes are never high together.
- R7: Bit 3 of `adc_d` is the Gray MSB. The binary value is b3=g3, b2=b3^g2, b1=b2^g1, b0=b1^g0. For example, 0011 gives 2, 0110 gives 4 and 1000 gives 15.
- R8: While `enable` is low, no strobe is produced and the value outputs do not change, even with all data lines high.
- R9: `fs_value` and `tc_value` change only in a cycle in which their own strobe is high, and they hold their value until that stream's next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Receiver enable; low powers the receiver down |
| adc_d | input | 4 | Gray-coded converter output, bit 3 is the MSB |
| conv_clk | output | 1 | Converter clock to the receiver |
| rx_pwr_dn | output | 1 | Power-down control to the receiver, 1 = off |
| fs_valid | output | 1 | One-cycle strobe for a new field-strength sample |
| fs_value | output | 4 | Binary field-strength value |
| tc_valid | output | 1 | One-cycle strobe for a new time-code sample |
| tc_value | output | 4 | Binary time-code amplitude value |

## Verification
The assertions check, on every cycle, the relations that hold locally. The strobe must match the converter clock level, and the two strobes must never overlap. Each strobe must follow a capture point that was reached after start-up. The power-down line must track the enable input, and the decoded value must equal the reduction-XOR form of the data lines seen one cycle earlier. The exact spacing of the converter clock edges, the capture offset inside each phase, the restart of the start-up interval on re-enable and the value hold between strobes need whole sequences. Only the bench's cycle-by-cycle model, run across enable and disable episodes and changing data patterns, shows these.

// File: rtl/gray_adc_pkg.sv
package gray_adc_pkg;

  localparam int DATA_W = 4;

  typedef logic [DATA_W-1:0] code_t;

  // XOR cascade from the most significant bit downwards.
  function automatic code_t gray2bin(input code_t g);
    code_t b;
    b[DATA_W-1] = g[DATA_W-1];
    for (int i = DATA_W - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/conv_phase_gen.sv
// Divides the system clock into the converter clock and marks the
// capture point inside each half period.
module conv_phase_gen #(
  parameter int HALF_TICKS    = 5000,
  parameter int CAPTURE_TICKS = 2500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic conv_clk,
  output logic cap_pt
);

  localparam int PW = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;
  localparam logic [PW-1:0] LAST_IDX = PW'(HALF_TICKS - 1);
  localparam logic [PW-1:0] CAP_IDX  = PW'(CAPTURE_TICKS - 1);

  logic [PW-1:0] ph_cnt;
  logic          wrap;

  assign wrap   = (ph_cnt == LAST_IDX);
  assign cap_pt = run && (ph_cnt == CAP_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_cnt   <= '0;
      conv_clk <= 1'b0;
    end else if (!run) begin
      ph_cnt   <= '0;
      conv_clk <= 1'b0;
    end else if (wrap) begin
      ph_cnt   <= '0;
      conv_clk <= ~conv_clk;
    end else begin
      ph_cnt   <= ph_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/setup_timer.sv
// Counts enabled cycles after power-up and saturates at the settle limit.
module setup_timer #(
  parameter int SETUP_TICKS = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic setup_done
);

  localparam int SW = $clog2(SETUP_TICKS + 1);
  localparam logic [SW-1:0] LIMIT = SW'(SETUP_TICKS);

  logic [SW-1:0] st_cnt;

  assign setup_done = (st_cnt == LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_cnt <= '0;
    end else if (!run) begin
      st_cnt <= '0;
    end else if (!setup_done) begin
      st_cnt <= st_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/sample_capture.sv
// Samples the data lines at the capture point and routes the decoded
// value to the stream chosen by the converter clock level.
module sample_capture
  import gray_adc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  take,
  input  logic  phase_hi,
  input  code_t din,
  output logic  fs_valid,
  output code_t fs_value,
  output logic  tc_valid,
  output code_t tc_value
);

  code_t dec;
  assign dec = gray2bin(din);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_valid <= 1'b0;
      tc_valid <= 1'b0;
      fs_value <= '0;
      tc_value <= '0;
    end else begin
      fs_valid <= take && phase_hi;
      tc_valid <= take && !phase_hi;
      if (take && phase_hi)  fs_value <= dec;
      if (take && !phase_hi) tc_value <= dec;
    end
  end

endmodule

// File: rtl/gray_adc_sampler.sv
module gray_adc_sampler
  import gray_adc_pkg::*;
#(
  parameter int HALF_TICKS    = 5000,
  parameter int CAPTURE_TICKS = 2500,
  parameter int SETUP_TICKS   = 500000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic [3:0]  adc_d,
  output logic        conv_clk,
  output logic        rx_pwr_dn,
  output logic        fs_valid,
  output logic [3:0]  fs_value,
  output logic        tc_valid,
  output logic [3:0]  tc_value
);

  // Named internal events, observed by the bound checker.
  logic cap_pt;
  logic setup_done;
  logic take_sample;

  conv_phase_gen #(
    .HALF_TICKS    (HALF_TICKS),
    .CAPTURE_TICKS (CAPTURE_TICKS)
  ) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (enable),
    .conv_clk (conv_clk),
    .cap_pt   (cap_pt)
  );

  setup_timer #(
    .SETUP_TICKS (SETUP_TICKS)
  ) u_setup (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (enable),
    .setup_done (setup_done)
  );

  assign take_sample = cap_pt && setup_done;

  sample_capture u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take_sample),
    .phase_hi (conv_clk),
    .din      (adc_d),
    .fs_valid (fs_valid),
    .fs_value (fs_value),
    .tc_valid (tc_valid),
    .tc_value (tc_value)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_pwr_dn <= 1'b1;
    else        rx_pwr_dn <= !enable;
  end

endmodule

// File: rtl/gray_adc_sampler_chk.sv
module gray_adc_sampler_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic [3:0] adc_d,
  input logic       conv_clk,
  input logic       rx_pwr_dn,
  input logic       fs_valid,
  input logic [3:0] fs_value,
  input logic       tc_valid,
  input logic [3:0] tc_value,
  input logic       cap_pt,
  input logic       setup_done
);

  logic [3:0] red_bin;
  assign red_bin = {^adc_d[3:3], ^adc_d[3:2], ^adc_d[3:1], ^adc_d[3:0]};

  a_r2_pwr_off: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> rx_pwr_dn);
  a_r2_pwr_on: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> !rx_pwr_dn);
  a_r3_park_low: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !conv_clk);
  a_r4_after_setup: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_valid || tc_valid) |-> $past(setup_done));
  a_r5_at_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_valid || tc_valid) |-> $past(cap_pt));
  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(fs_valid && tc_valid));
  a_r6_fs_high: assert property (@(posedge clk) disable iff (!rst_n)
    fs_valid |-> conv_clk);
  a_r6_tc_low: assert property (@(posedge clk) disable iff (!rst_n)
    tc_valid |-> !conv_clk);
  a_r6_single_fs: assert property (@(posedge clk) disable iff (!rst_n)
    fs_valid |=> !fs_valid);
  a_r7_fs_decode: assert property (@(posedge clk) disable iff (!rst_n)
    fs_valid |-> (fs_value == $past(red_bin)));
  a_r7_tc_decode: assert property (@(posedge clk) disable iff (!rst_n)
    tc_valid |-> (tc_value == $past(red_bin)));
  a_r8_no_strobe_off: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_valid || tc_valid) |-> !rx_pwr_dn);
  a_r9_fs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !fs_valid |=> (fs_valid || $stable(fs_value)));
  a_r9_tc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tc_valid |=> (tc_valid || $stable(tc_value)));

endmodule

bind gray_adc_sampler gray_adc_sampler_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .adc_d      (adc_d),
  .conv_clk   (conv_clk),
  .rx_pwr_dn  (rx_pwr_dn),
  .fs_valid   (fs_valid),
  .fs_value   (fs_value),
  .tc_valid   (tc_valid),
  .tc_value   (tc_value),
  .cap_pt     (cap_pt),
  .setup_done (setup_done)
);

// File: tb/gray_adc_sampler_test.sv
module gray_adc_sampler_test;

  localparam int HALF  = 8;
  localparam int CAPT  = 3;
  localparam int SETUP = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic [3:0] adc_d = 4'hF;
  logic       conv_clk, rx_pwr_dn, fs_valid, tc_valid;
  logic [3:0] fs_value, tc_value;

  int total = 0;
  int fails = 0;

  // reference model state
  int n_en = 0;
  int e_conv = 0, e_pwr = 1, e_fs = 0, e_tc = 0, e_fsv = 0, e_tcv = 0;
  int fs_seen = 0, tc_seen = 0, early_strobes = 0;

  always #2 clk = ~clk;

  gray_adc_sampler #(
    .HALF_TICKS    (HALF),
    .CAPTURE_TICKS (CAPT),
    .SETUP_TICKS   (SETUP)
  ) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .adc_d     (adc_d),
    .conv_clk  (conv_clk),
    .rx_pwr_dn (rx_pwr_dn),
    .fs_valid  (fs_valid),
    .fs_value  (fs_value),
    .tc_valid  (tc_valid),
    .tc_value  (tc_value)
  );

  // Decode by search: the value whose Gray image equals the code.
  function automatic int gray_value(input logic [3:0] g);
    for (int v = 0; v < 16; v++) begin
      if (((v ^ (v >> 1)) & 15) == int'(g)) return v;
    end
    return -1;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Advance the model by one rising edge with the inputs that were present.
  task automatic model_step();
    int m;
    bit strobe, hi;
    e_fs = 0;
    e_tc = 0;
    if (enable) begin
      n_en++;
      m      = n_en - 1;
      strobe = ((m % HALF) == CAPT - 1) && (m >= SETUP);
      hi     = ((m / HALF) % 2) == 1;
      e_conv = (n_en / HALF) % 2;
      e_pwr  = 0;
      if (strobe && hi)  begin e_fs = 1; e_fsv = gray_value(adc_d); end
      if (strobe && !hi) begin e_tc = 1; e_tcv = gray_value(adc_d); end
    end else begin
      n_en   = 0;
      e_conv = 0;
      e_pwr  = 1;
    end
  endtask

  task automatic compare_all();
    check("R2 rx_pwr_dn", int'(rx_pwr_dn), e_pwr);
    check("R3 conv_clk", int'(conv_clk), e_conv);
    check("R5/R6 fs_valid", int'(fs_valid), e_fs);
    check("R5/R6 tc_valid", int'(tc_valid), e_tc);
    check("R7/R9 fs_value", int'(fs_value), e_fsv);
    check("R7/R9 tc_value", int'(tc_value), e_tcv);
    if (fs_valid) fs_seen++;
    if (tc_valid) tc_seen++;
    if ((fs_valid || tc_valid) && enable && n_en <= SETUP) early_strobes++;
  endtask

  // One cycle: observe the edge just past, then drive new inputs.
  task automatic cycle(input logic en_nxt, input logic [3:0] d_nxt);
    @(negedge clk);
    model_step();
    compare_all();
    enable = en_nxt;
    adc_d  = d_nxt;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin : stim
    int g;
    repeat (4) @(negedge clk);
    // R1: reset values
    check("R1 rx_pwr_dn", int'(rx_pwr_dn), 1);
    check("R1 conv_clk", int'(conv_clk), 0);
    check("R1 fs_valid", int'(fs_valid), 0);
    check("R1 tc_valid", int'(tc_valid), 0);
    check("R1 fs_value", int'(fs_value), 0);
    check("R1 tc_value", int'(tc_value), 0);
    rst_n = 1'b1;
    cycle(1'b0, 4'hF);
    check("R1 after reset pwr", int'(rx_pwr_dn), 1);

    // Main run with data stepping through every Gray code.
    for (int k = 0; k < 200; k++) begin
      g = (k ^ (k >> 1)) & 15;
      cycle(1'b1, 4'(g));
    end
    check("R4 no strobe during start-up", early_strobes, 0);
    check("R6 field-strength samples seen", int'(fs_seen > 0), 1);
    check("R6 time-code samples seen", int'(tc_seen > 0), 1);

    // R8: powered down with all-high data, no strobe and values held.
    fs_seen = 0;
    tc_seen = 0;
    for (int k = 0; k < 40; k++) cycle(1'b0, 4'hF);
    check("R8 no strobe while disabled", fs_seen + tc_seen, 0);

    // R4: re-enable restarts start-up; R7 fixed patterns.
    for (int k = 0; k < 3 * HALF + SETUP; k++) cycle(1'b1, 4'b0011);
    check("R4 no strobe after re-enable start-up", early_strobes, 0);
    check("R7 0011 -> 2 field", int'(fs_value), 2);
    check("R7 0011 -> 2 time", int'(tc_value), 2);
    for (int k = 0; k < 2 * HALF; k++) cycle(1'b1, 4'b1000);
    check("R7 1000 -> 15 field", int'(fs_value), 15);
    check("R7 1000 -> 15 time", int'(tc_value), 15);
    for (int k = 0; k < 2 * HALF; k++) cycle(1'b1, 4'b0110);
    check("R7 0110 -> 4 field", int'(fs_value), 4);
    check("R7 0110 -> 4 time", int'(tc_value), 4);

    // R3: short disable pulse restarts converter clock timing.
    cycle(1'b0, 4'b0001);
    for (int k = 0; k < 4 * HALF + SETUP; k++) cycle(1'b1, 4'(k & 15));
    cycle(1'b0, 4'hF);
    cycle(1'b0, 4'hF);

    summary();
    $finish;
  end

endmodule